// File: doc/BRIEF.md
# Self-Correcting Pipelined Byte Substitution Unit

This block performs the forward AES byte substitution on one byte per clock. It does not use a lookup table. The substitution is built from combinational logic split into four register-separated stages. Stages one to three compute the multiplicative inverse in GF(2^8), using the reduction polynomial x^8+x^4+x^3+x+1, by raising the byte to the 254th power. A zero byte maps to zero. Stage four applies the affine transform with constant 0x63.

Each stage is built twice. The two copies are compared whenever the stage holds valid data. A disagreement raises that stage's error flag and the `busy` output. While any flag is high, a small controller freezes every pipeline register, including the output register. The stage in error recomputes from its frozen input on every cycle, and the pipeline advances again in the first cycle that all comparisons agree.

A transient fault of any length therefore costs exactly its length in cycles. No byte is lost, repeated or corrupted. Upstream logic must keep `in_valid` and `in_data` steady while `busy` is high. A test-only mask input per stage flips bits in one copy's result, so that faults can be injected.

The controller has two named states:
- CT_RUN: the pipeline advances.
- CT_HOLD: the pipeline is frozen.

It has two named transitions:
- trip (CT_RUN to CT_HOLD): taken in a cycle where any stage error is high.
- clear (CT_HOLD to CT_RUN): taken in a cycle where no stage error is high.

The advance decision itself is taken from the error flags in the same cycle. A bad result is therefore never registered.

Top module: `aes_sbox_ft`

## Requirements
- R1: Every byte accepted at the input is returned on `out_data` as its AES forward substitution value. Examples: 0x00 gives 0x63, 0x01 gives 0x7C, and 0x53 gives 0xED.
- R2: With no fault present, a byte accepted at clock edge k appears with `out_valid` high in the cycle after edge k+3. This is a latency of four cycles.
- R3: With no fault present, bytes presented on consecutive cycles are accepted one per cycle and leave one per cycle.
- R4: `fault_mask[8s+7:8s]` belongs to stage s, with s from 0 to 3. When that field is nonzero while stage s holds valid data, `busy` is high in that same cycle. Stage 0 holds valid data when `in_valid` is high.
- R5: After any cycle with `busy` high, `out_data` keeps its previous value and the internal stage valid bits are unchanged.
- R6: A byte is accepted only at an edge where `in_valid` is high and `busy` is low. Every accepted byte is output exactly once, in the order accepted.
- R7: Faults that keep `busy` high for D cycles delay every output that follows by exactly D cycles. This holds for a fault on any stage and for faults on several stages at once.
- R8: `out_valid` is low in the cycle after any cycle in which `busy` was high.
- R9: A synchronous active-high `rst` clears all valid bits. After reset, `out_valid` and `busy` are low, and bytes that were in flight are never output.
- R10: A nonzero mask on a stage that holds no valid data has no effect. `busy` stays low and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Byte to substitute |
| busy | output | 1 | A stage comparison failed this cycle; the input is not taken |
| out_valid | output | 1 | One-cycle pulse marking a substituted byte |
| out_data | output | 8 | Substituted byte; held during a freeze |
| fault_mask | input | 32 | Test-only; 8 bits per stage, XORed into the second copy's result |

## Verification
In a fault-free run, an output is due in the cycle after the fourth rising edge counted from its acceptance edge. A stream of n bytes therefore ends n+2 cycles after its first acceptance edge, plus one cycle for each cycle in which `busy` was high. The bench drives inputs 2 ns after each rising edge and samples on the falling edge. It records the cycle number of the first acceptance edge and of the last output pulse, then compares their difference against that count. `busy` is checked in the same cycle a mask is applied. `out_valid` and the held `out_data` are checked one cycle after each busy cycle.

// File: rtl/aes_sbox_ft_pkg.sv
package aes_sbox_ft_pkg;

    parameter int DW   = 8;
    parameter int NSTG = 4;
    parameter int PW   = 2 * DW;

    typedef logic [PW-1:0] payload_t;
    typedef logic [DW-1:0] elem_t;

    typedef enum logic {
        CT_RUN  = 1'b0,
        CT_HOLD = 1'b1
    } ctl_state_t;

    // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic elem_t gf_mul(input elem_t a, input elem_t b);
        elem_t acc;
        elem_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < DW; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[DW-2:0], 1'b0} ^ (sh[DW-1] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    // repeated squaring: a^(2^n)
    function automatic elem_t gf_sqn(input elem_t a, input int n);
        elem_t r;
        r = a;
        for (int i = 0; i < n; i++) r = gf_mul(r, r);
        return r;
    endfunction

    function automatic elem_t rotl(input elem_t a, input int n);
        elem_t r;
        r = a;
        for (int i = 0; i < n; i++) r = {r[DW-2:0], r[DW-1]};
        return r;
    endfunction

    function automatic elem_t affine(input elem_t b);
        return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
    endfunction

    // one pipeline step of x -> affine(x^254)
    //  step 0: x          -> {x^2,  x^3}
    //  step 1: {x^2, x^3} -> {x^14, x^15}
    //  step 2: {x^14,x^15}-> {0, x^254}
    //  step 3: {0, inv}   -> {0, affine(inv)}
    function automatic payload_t eval_step(input int stg, input payload_t din);
        elem_t    hi, lo, t, u;
        payload_t r;
        hi = din[PW-1:DW];
        lo = din[DW-1:0];
        r  = '0;
        unique case (stg)
            0: begin
                t = gf_mul(lo, lo);
                r = {t, gf_mul(t, lo)};
            end
            1: begin
                t = gf_sqn(lo, 2);
                r = {gf_mul(t, hi), gf_mul(t, lo)};
            end
            2: begin
                u = gf_sqn(lo, 4);
                r = {elem_t'(0), gf_mul(u, hi)};
            end
            default: begin
                r = {elem_t'(0), affine(lo)};
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sbox_dmr_stage.sv
module sbox_dmr_stage
    import aes_sbox_ft_pkg::*;
#(
    parameter int STG = 0
) (
    input  payload_t din,
    input  logic     v_in,
    input  elem_t    mask,
    output payload_t dout,
    output logic     err
);

    localparam int NCOPY = 2;

    payload_t res [NCOPY];

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        payload_t raw;
        always_comb begin
            raw = eval_step(STG, din);
        end
        if (c == NCOPY - 1) begin : g_inj
            assign res[c] = raw ^ {elem_t'(0), mask};
        end else begin : g_plain
            assign res[c] = raw;
        end
    end

    assign dout = res[0];
    assign err  = v_in && (res[0] != res[NCOPY-1]);

endmodule

// File: rtl/sbox_pipe_ctrl.sv
module sbox_pipe_ctrl
    import aes_sbox_ft_pkg::*;
#(
    parameter int N = NSTG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] err_vec,
    output logic         adv,
    output logic         busy,
    output ctl_state_t   state
);

    ctl_state_t state_nx;
    logic       any_err;

    assign any_err = |err_vec;

    always_ff @(posedge clk) begin
        if (rst) state <= CT_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        adv      = 1'b0;
        busy     = 1'b0;
        unique case (state)
            CT_RUN: begin
                adv  = !any_err;
                busy = any_err;
                if (any_err) state_nx = CT_HOLD;   // trip
            end
            CT_HOLD: begin
                adv  = !any_err;
                busy = any_err;
                if (!any_err) state_nx = CT_RUN;   // clear
            end
        endcase
    end

endmodule

// File: rtl/aes_sbox_ft.sv
module aes_sbox_ft
    import aes_sbox_ft_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DW-1:0]      in_data,
    output logic               busy,
    output logic               out_valid,
    output logic [DW-1:0]      out_data,
    input  logic [NSTG*DW-1:0] fault_mask
);

    localparam int LAST = NSTG - 1;

    payload_t        st_in  [NSTG];
    payload_t        st_out [NSTG];
    payload_t        pipe_q [NSTG];
    logic [NSTG-1:0] st_vin;
    logic [NSTG-1:0] st_err;
    logic [NSTG-1:0] vld_q;
    logic            adv;
    ctl_state_t      ctl_state;

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign st_in[k]  = {elem_t'(0), in_data};
            assign st_vin[k] = in_valid;
        end else begin : g_body
            assign st_in[k]  = pipe_q[k-1];
            assign st_vin[k] = vld_q[k-1];
        end

        sbox_dmr_stage #(.STG(k)) u_stage (
            .din  (st_in[k]),
            .v_in (st_vin[k]),
            .mask (fault_mask[k*DW +: DW]),
            .dout (st_out[k]),
            .err  (st_err[k])
        );
    end

    sbox_pipe_ctrl #(.N(NSTG)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .err_vec (st_err),
        .adv     (adv),
        .busy    (busy),
        .state   (ctl_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int k = 0; k < NSTG; k++) pipe_q[k] <= '0;
        end else if (adv) begin
            for (int k = 0; k < NSTG; k++) begin
                vld_q[k] <= st_vin[k];
                if (st_vin[k]) pipe_q[k] <= st_out[k];
            end
        end else begin
            // frozen: the output pulse must not repeat
            vld_q[LAST] <= 1'b0;
        end
    end

    assign out_valid = vld_q[LAST] && (ctl_state == CT_RUN);
    assign out_data  = pipe_q[LAST][DW-1:0];

endmodule

// File: rtl/aes_sbox_ft_chk.sv
module aes_sbox_ft_chk
    import aes_sbox_ft_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               busy,
    input logic               out_valid,
    input logic [DW-1:0]      out_data,
    input logic [NSTG*DW-1:0] fault_mask,
    input logic [NSTG-2:0]    pipe_vld
);

    AST_ERR_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fault_mask[DW-1:0] != '0) |-> busy);                 // R4

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(out_data));                                      // R5

    AST_HOLD_PIPE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pipe_vld));                                      // R5

    AST_NO_VALID_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
        busy |=> !out_valid);                                             // R8

    AST_IDLE_FAULT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && pipe_vld == '0) |-> !busy);                         // R10

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid);                                              // R9

endmodule

bind aes_sbox_ft aes_sbox_ft_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .fault_mask (fault_mask),
    .pipe_vld   (vld_q[NSTG-2:0])
);

// File: tb/aes_sbox_ft_test.sv
`timescale 1ns/1ps
module aes_sbox_ft_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        busy;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [31:0] fault_mask = 32'h0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] golden [256];
    logic [7:0] got [512];
    int         n_got = 0;
    int         last_out = 0;
    int         first_acc = 0;
    logic       prev_busy = 1'b0;
    logic [7:0] prev_data = 8'h00;

    aes_sbox_ft uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .busy(busy), .out_valid(out_valid), .out_data(out_data),
        .fault_mask(fault_mask)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // independent reference: Horner-form field product, search for inverse
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        p = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            p = p[7] ? ({p[6:0], 1'b0} ^ 8'h1B) : {p[6:0], 1'b0};
            if (a[i]) p = p ^ b;
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_affine(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
        return r;
    endfunction

    initial begin
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv;
            inv = 8'h00;
            for (int b = 1; b < 256; b++)
                if (ref_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            golden[a] = ref_affine(inv);
        end
    end

    // output monitor, falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_busy) begin
                check(!out_valid, "R8 out_valid after busy", int'(out_valid), 0);
                check(out_data == prev_data, "R5 out_data held", int'(out_data), int'(prev_data));
            end
            if (out_valid && n_got < 512) begin
                got[n_got] = out_data;
                n_got++;
                last_out = cyc;
            end
        end
        prev_busy = busy && !rst;
        prev_data = out_data;
    end

    task automatic sender(input int n, input int start);
        for (int i = 0; i < n; i++) begin
            bit ok;
            in_valid = 1'b1;
            in_data  = 8'((start + i) % 256);
            do begin
                @(negedge clk);
                ok = !busy;
                @(posedge clk);
                #2;
            end while (!ok);
            if (i == 0) first_acc = cyc;
        end
        in_valid = 1'b0;
    endtask

    task automatic injector(input int stmask, input int fdelay, input int fdur);
        logic [31:0] m;
        m = 32'h0;
        for (int s = 0; s < 4; s++)
            if (stmask[s]) m[s*8 +: 8] = 8'(8'h01 << s);
        repeat (fdelay) @(posedge clk);
        #2;
        fault_mask = m;
        @(negedge clk);
        check(busy == 1'b1, "R4 busy on mismatch", int'(busy), 1);
        repeat (fdur) @(posedge clk);
        #2;
        fault_mask = 32'h0;
    endtask

    task automatic run_stream(input int n, input int start, input int stmask,
                              input int fdelay, input int fdur, input string tag);
        n_got = 0;
        fork
            sender(n, start);
            if (stmask != 0) injector(stmask, fdelay, fdur);
        join
        repeat (fdur + 8) @(posedge clk);
        #2;
        check(n_got == n, {tag, " R6 output count"}, n_got, n);
        for (int i = 0; i < n && i < n_got; i++)
            check(got[i] == golden[(start + i) % 256], {tag, " R1 value"},
                  int'(got[i]), int'(golden[(start + i) % 256]));
        check(last_out - first_acc == n + 2 + fdur, {tag, " timing"},
              last_out - first_acc, n + 2 + fdur);
    endtask

    task automatic t_reset_state;
        check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        check(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    endtask

    task automatic t_idle_fault;
        @(posedge clk); #2;
        fault_mask = 32'hFFFF_FFFF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(busy == 1'b0, "R10 busy with idle fault", int'(busy), 0);
            check(out_valid == 1'b0, "R10 out_valid with idle fault", int'(out_valid), 0);
        end
        @(posedge clk); #2;
        fault_mask = 32'h0;
    endtask

    task automatic t_reset_flush;
        n_got = 0;
        in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            in_data = 8'(8'hA0 + i);
            @(posedge clk); #2;
        end
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        repeat (6) @(posedge clk);
        #2;
        check(n_got == 0, "R9 in-flight bytes dropped by reset", n_got, 0);
        t_reset_state();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        @(posedge clk); #2;

        run_stream(1, 8'h00, 0, 0, 0, "R2 single 00");
        run_stream(1, 8'h01, 0, 0, 0, "R2 single 01");
        run_stream(1, 8'h53, 0, 0, 0, "R2 single 53");
        run_stream(256, 0, 0, 0, 0, "R3 full sweep");
        run_stream(20, 8'h10, 4'b0001, 6, 3, "R7 stage0 fault");
        run_stream(20, 8'h30, 4'b0010, 6, 1, "R7 stage1 fault");
        run_stream(20, 8'h50, 4'b0100, 6, 5, "R7 stage2 fault");
        run_stream(20, 8'h70, 4'b1000, 6, 2, "R7 stage3 fault");
        run_stream(20, 8'hF0, 4'b1011, 7, 4, "R7 multi-stage fault");
        t_idle_fault();
        t_reset_flush();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule